// File: doc/BRIEF.md
# Multi-Block Frame Sequencer and Checker

This block follows a received frame made of fixed-size blocks, one byte per valid strobe. A start-of-frame pulse, raised by the sync detector upstream, opens a frame. The first block of every frame is a header, and it is protected by its own CRC. One byte of the header states how many blocks follow it. The block data never marks a block as the last one. The sequencer finds the last block only by counting down the number taken from the header. Every block between the header and the last block is an intermediate block with payload only. A second CRC sits at the end of the last block and covers the bytes of all the intermediate blocks together with the last block.

The block shows the type of the block now being received. When a block ends, it raises a done pulse that carries that block's type. It reports the header CRC result with the header's done pulse, and the frame CRC result with the last block's done pulse. When a header fails its CRC, the rest of the frame is dropped and the sequencer waits for the next start-of-frame pulse. When a start-of-frame pulse comes in the middle of a frame, the current frame is given up and a new header is received.

Top module: `frame_seq`

## Requirements
- R1: After reset, blk_type_o is 00 and every pulse output (blk_done_o, hdr_ok_o, hdr_err_o, frm_ok_o, frm_err_o) is low.
- R2: A start-of-frame pulse puts the sequencer at the first byte of a header, from any state, including the middle of a frame. From the next cycle, blk_type_o reads 01 (header). A byte strobed in the same cycle as the pulse is ignored.
- R3: The header ends after BLK_BYTES accepted bytes. In the cycle after the final header byte, blk_done_o pulses with done_type_o = 01. CRC1 is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, shifted MSB first with no reflection and no final XOR. It runs over the whole header, whose last two bytes are the CRC, high byte first. When it checks good, hdr_ok_o pulses together with the done pulse.
- R4: When CRC1 fails, hdr_err_o pulses with the header's done pulse. Every byte after that produces no output and leaves blk_type_o at 00 until the next start-of-frame pulse.
- R5: The following-block count is the unsigned header byte at index HDR_CNT_IDX, counted from 0. It is used only when CRC1 passes. A count of zero ends the frame after the header: blk_type_o returns to 00 and no frame CRC result is reported.
- R6: For a count N of 1 or more, the N-1 blocks after the header are intermediate (blk_type_o and done_type_o = 10) and block N is the last (11). Each block raises one blk_done_o pulse, in the cycle after its final byte.
- R7: CRC2 uses the same CRC as CRC1. It is started fresh at the first block after the header and runs on, without a restart, across all intermediate bytes and all last-block bytes. The final two bytes of the last block hold the CRC, high byte first. With the last block's done pulse, frm_ok_o pulses if CRC2 checks good and frm_err_o pulses if it does not.
- R8: Bytes strobed while no frame is open (after reset, or after a frame ends) are ignored.
- R9: Cycles with byte_vld_i low do not advance the byte position and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame pulse from sync detection |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Received byte |
| blk_type_o | output | 2 | Type of block in progress: 00 none, 01 header, 10 intermediate, 11 last |
| blk_done_o | output | 1 | Pulse one cycle after a block's final byte |
| done_type_o | output | 2 | Type of the block that just ended, valid with blk_done_o |
| hdr_ok_o | output | 1 | CRC1 good pulse |
| hdr_err_o | output | 1 | CRC1 bad pulse |
| frm_ok_o | output | 1 | CRC2 good pulse |
| frm_err_o | output | 1 | CRC2 bad pulse |

## Verification
The bench sends random frames with following-block counts from zero to several, with idle gaps between bytes, and with corrupted header or body bytes. If the design restarted CRC2 at each intermediate block, multi-block frames would fail their check. If it counted blocks off by one, the last block would be classed as intermediate, or the frame result would fire one block early. Directed cases cover three more faults. A start-of-frame pulse mid-frame that carries a junk byte breaks the next frame if the junk byte is counted. Bytes sent after a failed header must stay silent, or the header error has not stopped the frame. A count of zero must not produce a frame result.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [1:0] {
    BT_NONE  = 2'b00,
    BT_HDR   = 2'b01,
    BT_INTER = 2'b10,
    BT_LAST  = 2'b11
  } blk_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_BODY
  } seq_state_e;

  // One byte through an MSB-first CRC-16 shift register.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc,
                                             input logic [7:0]  din,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = crc ^ {din, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/frame_seq_crc.sv
module frame_seq_crc #(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  din_i,
  output logic [15:0] crc_nxt_o
);
  import frame_seq_pkg::*;

  logic [15:0] crc_q;

  assign crc_nxt_o = crc16_step(crc_q, din_i, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= INIT;
    else if (clr_i)  crc_q <= INIT;
    else if (upd_i)  crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/frame_seq_idx.sv
module frame_seq_idx #(
  parameter int BLK_BYTES = 12,
  localparam int IW = $clog2(BLK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] idx_o,
  output logic          at_end_o
);
  logic [IW-1:0] idx_q;

  assign idx_o    = idx_q;
  assign at_end_o = (idx_q == IW'(BLK_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idx_q <= '0;
    else if (clr_i)              idx_q <= '0;
    else if (inc_i && at_end_o)  idx_q <= '0;
    else if (inc_i)              idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int          BLK_BYTES   = 12,
  parameter int          HDR_CNT_IDX = 2,
  parameter logic [15:0] CRC_POLY    = 16'h1021,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  localparam int         IW          = $clog2(BLK_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic [1:0] blk_type_o,
  output logic       blk_done_o,
  output logic [1:0] done_type_o,
  output logic       hdr_ok_o,
  output logic       hdr_err_o,
  output logic       frm_ok_o,
  output logic       frm_err_o
);
  import frame_seq_pkg::*;

  seq_state_e    state_q;
  logic [7:0]    cnt_tmp_q;
  logic [7:0]    rem_q;
  logic [IW-1:0] idx;
  logic          idx_end;
  logic [15:0]   crc1_nxt, crc2_nxt;

  // Named events
  logic take, in_hdr, in_body;
  logic hdr_end, hdr_pass, hdr_fail;
  logic body_end, last_blk, frm_end;

  assign in_hdr   = (state_q == ST_HDR);
  assign in_body  = (state_q == ST_BODY);
  assign take     = byte_vld_i && !sof_i && (in_hdr || in_body);
  assign hdr_end  = take && in_hdr && idx_end;
  assign hdr_pass = hdr_end && (crc1_nxt == 16'h0000);
  assign hdr_fail = hdr_end && (crc1_nxt != 16'h0000);
  assign last_blk = (rem_q == 8'd1);
  assign body_end = take && in_body && idx_end;
  assign frm_end  = body_end && last_blk;

  frame_seq_idx #(.BLK_BYTES(BLK_BYTES)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr_i(sof_i), .inc_i(take),
    .idx_o(idx), .at_end_o(idx_end)
  );

  frame_seq_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc_hdr (
    .clk(clk), .rst_n(rst_n), .clr_i(sof_i), .upd_i(take && in_hdr),
    .din_i(byte_i), .crc_nxt_o(crc1_nxt)
  );

  frame_seq_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc_frm (
    .clk(clk), .rst_n(rst_n), .clr_i(hdr_pass), .upd_i(take && in_body),
    .din_i(byte_i), .crc_nxt_o(crc2_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_tmp_q <= '0;
      rem_q     <= '0;
    end else begin
      if (take && in_hdr && idx == IW'(HDR_CNT_IDX)) cnt_tmp_q <= byte_i;
      if (sof_i)                      state_q <= ST_HDR;
      else if (hdr_fail)              state_q <= ST_IDLE;
      else if (hdr_pass)              state_q <= (cnt_tmp_q == 8'd0) ? ST_IDLE : ST_BODY;
      else if (frm_end)               state_q <= ST_IDLE;
      if (hdr_pass)                   rem_q <= cnt_tmp_q;
      else if (body_end && !last_blk) rem_q <= rem_q - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_done_o  <= 1'b0;
      done_type_o <= BT_NONE;
      hdr_ok_o    <= 1'b0;
      hdr_err_o   <= 1'b0;
      frm_ok_o    <= 1'b0;
      frm_err_o   <= 1'b0;
    end else begin
      blk_done_o  <= hdr_end || body_end;
      done_type_o <= hdr_end ? BT_HDR : (body_end ? (last_blk ? BT_LAST : BT_INTER) : BT_NONE);
      hdr_ok_o    <= hdr_pass;
      hdr_err_o   <= hdr_fail;
      frm_ok_o    <= frm_end && (crc2_nxt == 16'h0000);
      frm_err_o   <= frm_end && (crc2_nxt != 16'h0000);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_HDR:  blk_type_o = BT_HDR;
      ST_BODY: blk_type_o = last_blk ? BT_LAST : BT_INTER;
      default: blk_type_o = BT_NONE;
    endcase
  end
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof_i,
  input logic [1:0] blk_type_o,
  input logic       blk_done_o,
  input logic [1:0] done_type_o,
  input logic       hdr_ok_o,
  input logic       hdr_err_o,
  input logic       frm_ok_o,
  input logic       frm_err_o,
  input logic       hdr_end
);
  // R2: a start pulse opens a header
  assert_sof_hdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (blk_type_o == 2'b01));

  // R3: header results come only with a header done pulse, never both
  assert_hdr_res_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ok_o || hdr_err_o) |-> (blk_done_o && done_type_o == 2'b01 && !(hdr_ok_o && hdr_err_o)));

  // R3: the header's final byte is followed by a header done pulse
  assert_hdr_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_end |=> (blk_done_o && done_type_o == 2'b01));

  // R4: after a failed header the sequencer is idle
  assert_hdr_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err_o |-> (blk_type_o == 2'b00));

  // R7: frame result only with the last block, never both
  assert_frm_res_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ok_o || frm_err_o) |-> (blk_done_o && done_type_o == 2'b11 && !(frm_ok_o && frm_err_o)));

  // R6: the last block's done pulse closes the frame
  assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done_o && done_type_o == 2'b11) |-> (blk_type_o == 2'b00 || $past(sof_i)));

  // R6: a done pulse never carries the none type
  assert_done_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_o |-> (done_type_o != 2'b00));
endmodule

bind frame_seq frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .blk_type_o(blk_type_o),
  .blk_done_o(blk_done_o), .done_type_o(done_type_o), .hdr_ok_o(hdr_ok_o),
  .hdr_err_o(hdr_err_o), .frm_ok_o(frm_ok_o), .frm_err_o(frm_err_o),
  .hdr_end(hdr_end)
);

// File: tb/frame_seq_tb.sv
`timescale 1ns/1ps
module frame_seq_tb;
  localparam int BLK = 12;
  localparam int CIDX = 2;
  localparam int MAXB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sof_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [1:0] blk_type_o, done_type_o;
  logic blk_done_o, hdr_ok_o, hdr_err_o, frm_ok_o, frm_err_o;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  logic [7:0] hdr [BLK];
  logic [7:0] body [BLK*MAXB];

  always #4 clk = ~clk;

  frame_seq #(.BLK_BYTES(BLK), .HDR_CNT_IDX(CIDX)) u_dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .blk_type_o(blk_type_o), .blk_done_o(blk_done_o), .done_type_o(done_type_o),
    .hdr_ok_o(hdr_ok_o), .hdr_err_o(hdr_err_o), .frm_ok_o(frm_ok_o), .frm_err_o(frm_err_o)
  );

  // Bit-serial reference CRC: one message bit at a time.
  function automatic logic [15:0] ref_crc_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    c = {c[14:0], 1'b0};
    if (fb) c = c ^ 16'h1021;
    return c;
  endfunction

  function automatic logic [15:0] ref_crc_byte(input logic [15:0] c, input logic [7:0] d);
    for (int k = 7; k >= 0; k--) c = ref_crc_bit(c, d[k]);
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap();
    int n;
    n = $urandom_range(0, 3) == 0 ? $urandom_range(1, 2) : 0;
    for (int g = 0; g < n; g++) begin
      @(negedge clk);
      check("R9 gap no pulse", {blk_done_o, hdr_ok_o, hdr_err_o, frm_ok_o, frm_err_o}, 0);
    end
  endtask

  // Present a byte; check blk_type before the edge and pulses after it.
  task automatic push(input logic [7:0] b, input logic [1:0] bt, input logic dn,
                      input logic [1:0] dt, input logic hok, input logic herr,
                      input logic fok, input logic ferr, input string req);
    gap();
    check({req, " blk_type"}, blk_type_o, bt);
    byte_vld_i = 1'b1;
    byte_i = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
    check({req, " done"}, blk_done_o, dn);
    if (dn) check({req, " done_type"}, done_type_o, dt);
    check({req, " hdr_ok/err"}, {hdr_ok_o, hdr_err_o}, {hok, herr});
    check({req, " frm_ok/err"}, {frm_ok_o, frm_err_o}, {fok, ferr});
  endtask

  task automatic pulse_sof(input bit junk);
    sof_i = 1'b1;
    byte_vld_i = junk;
    byte_i = 8'hA5;
    @(negedge clk);
    sof_i = 1'b0;
    byte_vld_i = 1'b0;
    check("R2 header after sof", blk_type_o, 2'b01);
  endtask

  task automatic build(input int cnt, input bit bad_hdr, input bit bad_body);
    logic [15:0] c;
    int nb;
    for (int i = 0; i < BLK - 2; i++) hdr[i] = 8'($urandom);
    hdr[CIDX] = 8'(cnt);
    c = 16'hFFFF;
    for (int i = 0; i < BLK - 2; i++) c = ref_crc_byte(c, hdr[i]);
    hdr[BLK-2] = c[15:8];
    hdr[BLK-1] = c[7:0];
    if (bad_hdr) hdr[5] = hdr[5] ^ 8'h10;
    nb = cnt * BLK;
    if (nb > 0) begin
      c = 16'hFFFF;
      for (int i = 0; i < nb - 2; i++) begin
        body[i] = 8'($urandom);
        c = ref_crc_byte(c, body[i]);
      end
      body[nb-2] = c[15:8];
      body[nb-1] = c[7:0];
      if (bad_body) body[$urandom_range(0, nb-1)] ^= 8'h01;
    end
  endtask

  // Send a frame. stop_at >= 0 ends sending after that many body bytes.
  task automatic send(input int cnt, input bit bad_hdr, input bit bad_body, input int stop_at);
    bit last;
    bit fin;
    pulse_sof(1'b0);
    build(cnt, bad_hdr, bad_body);
    for (int i = 0; i < BLK; i++) begin
      fin = (i == BLK - 1);
      push(hdr[i], 2'b01, fin, 2'b01, fin && !bad_hdr, fin && bad_hdr, 1'b0, 1'b0, "R3/R4 header");
    end
    if (bad_hdr) begin
      for (int i = 0; i < 5; i++)
        push(8'($urandom), 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R4 ignored after error");
      return;
    end
    if (cnt == 0) begin
      push(8'($urandom), 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R5 zero count ends frame");
      return;
    end
    for (int j = 0; j < cnt * BLK; j++) begin
      if (stop_at >= 0 && j == stop_at) return;
      last = (j / BLK == cnt - 1);
      fin  = (j % BLK == BLK - 1);
      push(body[j], last ? 2'b11 : 2'b10, fin, last ? 2'b11 : 2'b10, 1'b0, 1'b0,
           fin && last && !bad_body, fin && last && bad_body, "R6/R7 body");
    end
    push(8'($urandom), 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R8 after frame end");
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset blk_type", blk_type_o, 0);
    check("R1 reset pulses", {blk_done_o, hdr_ok_o, hdr_err_o, frm_ok_o, frm_err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      push(8'($urandom), 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R8 idle bytes");
    send(0, 1'b0, 1'b0, -1);  // R5
    send(1, 1'b0, 1'b0, -1);  // R6 single last block
    send(3, 1'b0, 1'b0, -1);  // R7 CRC2 across blocks
    send(2, 1'b1, 1'b0, -1);  // R4
    send(3, 1'b0, 1'b1, -1);  // R7 error
    send(4, 1'b0, 1'b0, 17);  // R2 abort mid-frame
    pulse_sof(1'b1);          // R2 junk byte with sof ignored
    build(2, 1'b0, 1'b0);
    for (int i = 0; i < BLK; i++)
      push(hdr[i], 2'b01, i == BLK-1, 2'b01, i == BLK-1, 1'b0, 1'b0, 1'b0, "R2 restart header");
    for (int j = 0; j < 2 * BLK; j++)
      push(body[j], (j >= BLK) ? 2'b11 : 2'b10, j % BLK == BLK-1, (j >= BLK) ? 2'b11 : 2'b10,
           1'b0, 1'b0, j == 2*BLK-1, 1'b0, "R2 restart body");
    for (int f = 0; f < 40; f++) begin
      int r;
      r = $urandom_range(0, 9);
      send($urandom_range(0, MAXB - 1), r == 0, r == 1, (r == 2) ? $urandom_range(0, BLK) : -1);
    end
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule